// File: doc/BRIEF.md
# PCI Window Register Bank with Split 64-bit Access

This block is the configuration register bank of a PCI host bridge. It keeps the setup for several DMA address windows and one 64-bit bridge control register. Each window has a 32-bit base, a 32-bit mask and a translated base held as a page number. The windows and the control value leave the block on flat output buses for a translation datapath elsewhere on the chip.

Software reaches the bank over a 32-bit request bus, but the registers are 64 bits wide. Address bit 2 selects the half of a 64-bit register. A single temporary latch joins the two halves in both directions. A write to the lower half only stores its data in the latch. A write to the upper half builds a 64-bit value from the write data and the latch, and commits that value. A read of the lower half returns the low word and saves the high word in the latch. The next read of the upper half then returns that saved word, so the two halves come from the same moment.

Decoded offsets outside the map raise a one-cycle error pulse.

Top module: `pwin_csr_bank`

## Requirements
- R1: A write with address bit 2 clear stores its data in the latch and nothing else. No window or control output changes, and no error is raised, whatever the offset.
- R2: A write with address bit 2 set commits {write data, latch} to the register at that offset with bit 2 cleared. A base or mask register keeps only the low 32 bits of that value, which are the latch contents.
- R3: A read with address bit 2 clear returns bits 31:0 of the register and loads bits 63:32 into the latch. A read with address bit 2 set returns the latch without decoding the offset and never raises an error. Reads change no register.
- R4: Window i (0 to 3) has its base at 0x000 + 0x40·i, its mask at 0x100 + 0x40·i and its translated base at 0x200 + 0x40·i. Writes to one window leave every other window unchanged.
- R5: A commit to a translated base register stores bits 41:10 of the assembled value as a 32-bit page number. A read of it returns that page number shifted left by 10 and zero-extended to 64 bits.
- R6: The control register sits at 0x300. A commit changes only the bits set in 0x0000_001C_FF0F_C7FF, and every other bit keeps its value, which is 0 from reset.
- R7: Offsets 0x340, 0x3C0, 0x400, 0x440, 0x480, 0x4C0, 0x500, 0x540 and 0x800 read as zero, load zero into the latch on a lower-half read, ignore writes and raise no error.
- R8: A decoded access (lower-half read or upper-half write) to any other offset, including one with address bits 1:0 nonzero, raises err_pulse for one cycle. Such a read returns 0xFFFF_FFFF, and such an access changes neither the latch nor any register.
- R9: After reset every register and the latch are zero. Read data and rsp_valid appear on the cycle after the request, and rsp_valid and err_pulse are low when no request was made the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte offset within the bank |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | DATA_W (32) | Read data |
| err_pulse | output | 1 | Unassigned-offset access, one cycle |
| win_base_o | output | NWIN·DATA_W | Window base registers, window 0 in the low bits |
| win_mask_o | output | NWIN·DATA_W | Window mask registers |
| win_tpfn_o | output | NWIN·DATA_W | Translated base page numbers |
| ctl_o | output | 2·DATA_W | Bridge control register |

## Verification
The assertions assume that the request fields are known and steady whenever req_valid is high, and that each request lasts exactly one clock. They also assume that reset is held for at least one edge before the first request. The stimulus drives every request for a single cycle, a short delay after the falling edge, and uses only 12-bit offsets with defined data. Back-to-back requests with no idle cycle in between are part of the stimulus, because the shared latch must carry state from one request to the next. The latch contents are brought out only through upper-half reads, so each latch-related check reads the upper half right after the access being tested.

// File: rtl/pwin_pkg.sv
// Package: shared constants and types for the PCI window register bank.
// Assumes byte offsets of 12 bits and 32-bit bus halves of 64-bit registers.
package pwin_pkg;

    // Kind of register an offset selects after decode.
    typedef enum logic [2:0] {
        K_BASE = 3'd0,
        K_MASK = 3'd1,
        K_TBA  = 3'd2,
        K_CTL  = 3'd3,
        K_RAZ  = 3'd4,
        K_BAD  = 3'd5
    } csr_kind_e;

    // Writable bits of the bridge control register.
    localparam logic [63:0] CTL_WMASK = 64'h0000_001C_FF0F_C7FF;

    // Translated base is held as a page number; this is the page shift.
    localparam int PAGE_SHIFT = 10;

    // Width of the window slot field inside a register group.
    localparam int SLOT_W = 2;

endpackage

// File: rtl/pwin_decode.sv
// Module: offset decoder. Maps a byte offset to a register kind and a window
// slot. Address bit 2 (the half select) is ignored here; the caller decides
// whether a decode is needed at all. Assumes ADDR_W >= 12 and NWIN <= 4.
module pwin_decode
    import pwin_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NWIN   = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output csr_kind_e         kind,
    output logic [SLOT_W-1:0] slot
);

    localparam int GRP_W = ADDR_W - 8;

    logic [GRP_W-1:0] grp;
    logic             aligned;
    logic             win_ok;

    assign grp     = addr[ADDR_W-1:8];
    assign slot    = addr[7:6];
    assign aligned = (addr[1:0] == 2'b00) && (addr[5:3] == 3'b000);
    assign win_ok  = (32'(slot) < NWIN);

    // Classify the offset by its 256-byte group and its slot within it.
    always_comb begin
        kind = K_BAD;
        if (aligned) begin
            if (grp == GRP_W'(0)) begin
                kind = win_ok ? K_BASE : K_BAD;
            end else if (grp == GRP_W'(1)) begin
                kind = win_ok ? K_MASK : K_BAD;
            end else if (grp == GRP_W'(2)) begin
                kind = win_ok ? K_TBA : K_BAD;
            end else if (grp == GRP_W'(3)) begin
                if (slot == 2'd0) begin
                    kind = K_CTL;
                end else if (slot == 2'd1 || slot == 2'd3) begin
                    kind = K_RAZ;
                end
            end else if (grp == GRP_W'(4)) begin
                kind = K_RAZ;
            end else if (grp == GRP_W'(5)) begin
                if (slot[1] == 1'b0) begin
                    kind = K_RAZ;
                end
            end else if (grp == GRP_W'(8)) begin
                if (slot == 2'd0) begin
                    kind = K_RAZ;
                end
            end
        end
    end

endmodule

// File: rtl/pwin_split_latch.sv
// Module: the shared temporary word that joins 32-bit halves into 64-bit
// register accesses. Loads when load_en is high; otherwise holds.
module pwin_split_latch #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] q
);

    // Hold or reload the temporary word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load_en) begin
            q <= load_val;
        end
    end

endmodule

// File: rtl/pwin_window.sv
// Module: one DMA window: base, mask and translated page number. A commit
// supplies the assembled 64-bit value; base and mask keep its low word, the
// page number keeps bits [SHIFT +: TPFN_W]. Assumes at most one select high.
module pwin_window #(
    parameter int DATA_W = 32,
    parameter int TPFN_W = 32,
    parameter int SHIFT  = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_base,
    input  logic                wr_mask,
    input  logic                wr_tba,
    input  logic [2*DATA_W-1:0] val,
    output logic [DATA_W-1:0]   base_q,
    output logic [DATA_W-1:0]   mask_q,
    output logic [TPFN_W-1:0]   tpfn_q
);

    // Base register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_base) begin
            base_q <= val[DATA_W-1:0];
        end
    end

    // Mask register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_mask) begin
            mask_q <= val[DATA_W-1:0];
        end
    end

    // Translated base stored as a page number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpfn_q <= '0;
        end else if (wr_tba) begin
            tpfn_q <= val[SHIFT +: TPFN_W];
        end
    end

endmodule

// File: rtl/pwin_ctl_reg.sv
// Module: bridge control register. A commit replaces only the bits set in
// WMASK; the rest keep their stored value.
module pwin_ctl_reg #(
    parameter int          REG_W = 64,
    parameter logic [63:0] WMASK = 64'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] val,
    output logic [REG_W-1:0] q
);

    localparam logic [REG_W-1:0] M = WMASK[REG_W-1:0];

    // Masked merge of the committed value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            q <= (q & ~M) | (val & M);
        end
    end

endmodule

// File: rtl/pwin_csr_bank.sv
// Module: top of the PCI window register bank. Splits each 64-bit register
// into two 32-bit bus halves through one shared latch, decodes offsets,
// and returns read data one cycle after the request. Assumes one-cycle
// requests with known fields while req_valid is high.
module pwin_csr_bank
    import pwin_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int NWIN   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   err_pulse,
    output logic [NWIN*DATA_W-1:0] win_base_o,
    output logic [NWIN*DATA_W-1:0] win_mask_o,
    output logic [NWIN*DATA_W-1:0] win_tpfn_o,
    output logic [2*DATA_W-1:0]    ctl_o
);

    localparam int REG_W  = 2 * DATA_W;
    localparam int TPFN_W = DATA_W;

    csr_kind_e         kind;
    logic [SLOT_W-1:0] slot;
    logic              rd_lo, rd_hi, wr_lo, wr_hi;
    logic              is_bad;
    logic              commit;
    logic [REG_W-1:0]  assembled;
    logic [REG_W-1:0]  rd_val;
    logic [DATA_W-1:0] latch_q;
    logic              latch_en;
    logic [DATA_W-1:0] latch_d;

    logic [DATA_W-1:0] base_w [NWIN];
    logic [DATA_W-1:0] mask_w [NWIN];
    logic [TPFN_W-1:0] tpfn_w [NWIN];

    pwin_decode #(.ADDR_W(ADDR_W), .NWIN(NWIN)) u_dec (
        .addr (req_addr),
        .kind (kind),
        .slot (slot)
    );

    // Classify the request by direction and half.
    assign rd_lo = req_valid && !req_write && !req_addr[2];
    assign rd_hi = req_valid && !req_write &&  req_addr[2];
    assign wr_lo = req_valid &&  req_write && !req_addr[2];
    assign wr_hi = req_valid &&  req_write &&  req_addr[2];

    assign is_bad    = (rd_lo || wr_hi) && (kind == K_BAD);
    assign commit    = wr_hi && (kind != K_BAD);
    assign assembled = {req_wdata, latch_q};

    // Latch source: write data on a low write, high word on a good low read.
    always_comb begin
        latch_en = 1'b0;
        latch_d  = req_wdata;
        if (wr_lo) begin
            latch_en = 1'b1;
        end else if (rd_lo && !is_bad) begin
            latch_en = 1'b1;
            latch_d  = rd_val[REG_W-1:DATA_W];
        end
    end

    pwin_split_latch #(.DATA_W(DATA_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (latch_en),
        .load_val (latch_d),
        .q        (latch_q)
    );

    // One window instance per slot, each with its own commit selects.
    for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
        logic hit;
        assign hit = commit && (slot == SLOT_W'(gi));

        pwin_window #(
            .DATA_W (DATA_W),
            .TPFN_W (TPFN_W),
            .SHIFT  (PAGE_SHIFT)
        ) u_win (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_base (hit && (kind == K_BASE)),
            .wr_mask (hit && (kind == K_MASK)),
            .wr_tba  (hit && (kind == K_TBA)),
            .val     (assembled),
            .base_q  (base_w[gi]),
            .mask_q  (mask_w[gi]),
            .tpfn_q  (tpfn_w[gi])
        );

        assign win_base_o[gi*DATA_W +: DATA_W] = base_w[gi];
        assign win_mask_o[gi*DATA_W +: DATA_W] = mask_w[gi];
        assign win_tpfn_o[gi*DATA_W +: DATA_W] = tpfn_w[gi];
    end

    pwin_ctl_reg #(.REG_W(REG_W), .WMASK(CTL_WMASK)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (commit && (kind == K_CTL)),
        .val   (assembled),
        .q     (ctl_o)
    );

    // Select the 64-bit value a decoded read returns.
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NWIN; i++) begin
            if (slot == SLOT_W'(i)) begin
                if (kind == K_BASE) rd_val = REG_W'(base_w[i]);
                if (kind == K_MASK) rd_val = REG_W'(mask_w[i]);
                if (kind == K_TBA)  rd_val = REG_W'(tpfn_w[i]) << PAGE_SHIFT;
            end
        end
        if (kind == K_CTL) rd_val = ctl_o;
    end

    // Register the response and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            err_pulse <= 1'b0;
        end else begin
            rsp_valid <= rd_lo || rd_hi;
            err_pulse <= is_bad;
            if (rd_hi) begin
                rsp_rdata <= latch_q;
            end else if (rd_lo) begin
                rsp_rdata <= is_bad ? '1 : rd_val[DATA_W-1:0];
            end else begin
                rsp_rdata <= '0;
            end
        end
    end

endmodule

// File: rtl/pwin_csr_bank_chk.sv
// Module: assertion checker for the PCI window register bank, bound to the
// top. Assumes one-cycle requests with known fields under req_valid.
module pwin_csr_bank_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int NWIN   = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_write,
    input logic [ADDR_W-1:0]      req_addr,
    input logic [DATA_W-1:0]      req_wdata,
    input logic                   rsp_valid,
    input logic [DATA_W-1:0]      rsp_rdata,
    input logic                   err_pulse,
    input logic [NWIN*DATA_W-1:0] win_base_o,
    input logic [NWIN*DATA_W-1:0] win_mask_o,
    input logic [NWIN*DATA_W-1:0] win_tpfn_o,
    input logic [2*DATA_W-1:0]    ctl_o
);

    // R1: a lower-half write leaves every register output unchanged.
    p_lowwrite_keeps_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_addr[2]) |=>
            ($stable(win_base_o) && $stable(win_mask_o) &&
             $stable(win_tpfn_o) && $stable(ctl_o)));

    // R1: a lower-half write never raises an error.
    p_lowwrite_noerr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_addr[2]) |=> !err_pulse);

    // R3: reads change no register.
    p_read_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=>
            ($stable(win_base_o) && $stable(win_mask_o) &&
             $stable(win_tpfn_o) && $stable(ctl_o)));

    // R3: an upper-half read is never flagged.
    p_hiread_noerr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[2]) |=> !err_pulse);

    // R6: bits outside the writable mask stay zero.
    p_ctl_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o & ~pwin_pkg::CTL_WMASK) == '0);

    // R8: an errored read returns all ones.
    p_err_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && rsp_valid) |-> (rsp_rdata == '1));

    // R8: the error pulse only follows a request.
    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(req_valid));

    // R9: a response follows a read one cycle later, and only a read.
    p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    p_rsp_due_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

endmodule

bind pwin_csr_bank pwin_csr_bank_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NWIN   (NWIN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .err_pulse  (err_pulse),
    .win_base_o (win_base_o),
    .win_mask_o (win_mask_o),
    .win_tpfn_o (win_tpfn_o),
    .ctl_o      (ctl_o)
);

// File: tb/sim_pwin_csr_bank.sv
// Bench: scoreboard. The driver task pushes the expected response of each
// request into a queue; a monitor pops and compares one cycle later.
`timescale 1ns/1ps
module sim_pwin_csr_bank;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int NWIN   = 4;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   req_valid = 1'b0;
    logic                   req_write = 1'b0;
    logic [ADDR_W-1:0]      req_addr = '0;
    logic [DATA_W-1:0]      req_wdata = '0;
    logic                   rsp_valid;
    logic [DATA_W-1:0]      rsp_rdata;
    logic                   err_pulse;
    logic [NWIN*DATA_W-1:0] win_base_o;
    logic [NWIN*DATA_W-1:0] win_mask_o;
    logic [NWIN*DATA_W-1:0] win_tpfn_o;
    logic [2*DATA_W-1:0]    ctl_o;

    pwin_csr_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NWIN(NWIN)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .err_pulse  (err_pulse),
        .win_base_o (win_base_o),
        .win_mask_o (win_mask_o),
        .win_tpfn_o (win_tpfn_o),
        .ctl_o      (ctl_o)
    );

    always #10 clk = ~clk;  // 50 MHz

    typedef struct {
        bit          rsp;
        logic [31:0] data;
        bit          err;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   total = 0;
    int   bad   = 0;
    bit   running = 1'b0;
    bit   ended   = 1'b0;

    localparam logic [63:0] CTLM = 64'h0000_001C_FF0F_C7FF;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Driver: one request for one cycle, expected response queued.
    task automatic req(input bit wr, input logic [11:0] a, input logic [31:0] d,
                       input logic [31:0] exp_d, input bit exp_e, input string tag);
        exp_t it;
        @(negedge clk);
        #1;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        it.rsp  = !wr;
        it.data = exp_d;
        it.err  = exp_e;
        it.tag  = tag;
        sb.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        #1;
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    // Monitor: compare each cycle's outputs with the oldest expectation.
    always @(negedge clk) begin
        if (running) begin
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                chk({it.tag, " rsp_valid"}, 64'(rsp_valid), 64'(it.rsp));
                chk({it.tag, " err_pulse"}, 64'(err_pulse), 64'(it.err));
                if (it.rsp) chk({it.tag, " rdata"}, 64'(rsp_rdata), 64'(it.data));
            end else begin
                chk("R9 quiet rsp_valid", 64'(rsp_valid), 64'd0);
                chk("R9 quiet err_pulse", 64'(err_pulse), 64'd0);
            end
        end
    end

    initial begin
        #(20 * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        logic [63:0] v;
        logic [63:0] tb_rd;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;

        // R9: reset state
        chk("R9 reset base", win_base_o, '0);
        chk("R9 reset mask", win_mask_o, '0);
        chk("R9 reset tpfn", win_tpfn_o, '0);
        chk("R9 reset ctl", ctl_o, '0);
        req(0, 12'h000, 0, 32'h0, 0, "R9 reset read");
        req(0, 12'h004, 0, 32'h0, 0, "R9 reset latch");

        // R1: lower write only loads the latch; even a bad offset is not flagged
        req(1, 12'h380, 32'h5555_AAAA, 0, 0, "R1 low write bad offset");
        req(1, 12'h000, 32'h1234_5678, 0, 0, "R1 low write");
        idle();
        chk("R1 base unchanged", win_base_o, '0);
        req(0, 12'h084, 0, 32'h1234_5678, 0, "R1 latch holds data");

        // R2: upper write commits; base keeps the latch word
        req(1, 12'h004, 32'hAAAA_BBBB, 0, 0, "R2 high write");
        idle();
        chk("R2 base0 port", win_base_o[31:0], 64'h1234_5678);
        req(0, 12'h000, 0, 32'h1234_5678, 0, "R2 base0 low");
        req(0, 12'h004, 0, 32'h0, 0, "R3 base0 high is zero");

        // R4: window 3 mask and base, independent of window 0
        req(1, 12'h1C0, 32'hFFF0_0000, 0, 0, "R4 mask3 lo");
        req(1, 12'h1C4, 32'h0000_DEAD, 0, 0, "R4 mask3 hi");
        req(1, 12'h0C0, 32'h0BAD_F00D, 0, 0, "R4 base3 lo");
        req(1, 12'h0C4, 32'h0, 0, 0, "R4 base3 hi");
        idle();
        chk("R4 mask3 port", win_mask_o[127:96], 64'hFFF0_0000);
        chk("R4 base3 port", win_base_o[127:96], 64'h0BAD_F00D);
        chk("R4 base0 kept", win_base_o[31:0], 64'h1234_5678);
        chk("R4 other masks", win_mask_o[95:0], '0);
        req(0, 12'h1C0, 0, 32'hFFF0_0000, 0, "R4 mask3 read");
        req(0, 12'h0C0, 0, 32'h0BAD_F00D, 0, "R4 base3 read");

        // R5: translated base page number
        v = 64'h0000_0123_4567_89AB;
        req(1, 12'h240, v[31:0], 0, 0, "R5 tba1 lo");
        req(1, 12'h244, v[63:32], 0, 0, "R5 tba1 hi");
        idle();
        chk("R5 tpfn1 port", win_tpfn_o[63:32], (v >> 10) & 64'hFFFF_FFFF);
        tb_rd = ((v >> 10) & 64'hFFFF_FFFF) << 10;
        req(0, 12'h240, 0, tb_rd[31:0], 0, "R5 tba1 read lo");
        req(0, 12'h244, 0, tb_rd[63:32], 0, "R5 tba1 read hi");
        req(1, 12'h2C0, 32'hFFFF_FFFF, 0, 0, "R5 tba3 lo");
        req(1, 12'h2C4, 32'hFFFF_FFFF, 0, 0, "R5 tba3 hi");
        req(0, 12'h2C0, 0, 32'hFFFF_FC00, 0, "R5 tba3 read lo");
        req(0, 12'h2C4, 0, 32'h0000_03FF, 0, "R5 tba3 read hi");

        // R7: reserved offsets read zero and clear the latch
        req(0, 12'h2C0, 0, 32'hFFFF_FC00, 0, "R7 prime latch");
        req(0, 12'h4C0, 0, 32'h0, 0, "R7 raz read");
        req(0, 12'h4C4, 0, 32'h0, 0, "R7 latch cleared");
        req(1, 12'h800, 32'h1, 0, 0, "R7 raz write lo");
        req(1, 12'h344, 32'hFFFF_FFFF, 0, 0, "R7 raz write hi");
        req(0, 12'h540, 0, 32'h0, 0, "R7 raz 0x540");
        idle();
        chk("R7 ctl unchanged", ctl_o, '0);

        // R8: unassigned offsets
        req(0, 12'h2C0, 0, 32'hFFFF_FC00, 0, "R8 prime latch");
        req(0, 12'h380, 0, 32'hFFFF_FFFF, 1, "R8 bad read");
        req(0, 12'h384, 0, 32'h0000_03FF, 0, "R3 high read bad offset, latch kept");
        req(1, 12'h604, 32'h0F0F_0F0F, 0, 1, "R8 bad write");
        req(0, 12'h001, 0, 32'hFFFF_FFFF, 1, "R8 misaligned read");
        req(0, 12'h008, 0, 32'hFFFF_FFFF, 1, "R8 offset 0x008");
        idle();
        chk("R8 base kept", win_base_o, {32'h0BAD_F00D, 64'h0, 32'h1234_5678});
        chk("R8 ctl kept", ctl_o, '0);

        // R6: control register masking
        req(1, 12'h300, 32'hFFFF_FFFF, 0, 0, "R6 ctl lo");
        req(1, 12'h304, 32'hFFFF_FFFF, 0, 0, "R6 ctl hi");
        idle();
        chk("R6 ctl port", ctl_o, CTLM);
        req(0, 12'h300, 0, CTLM[31:0], 0, "R6 ctl read lo");
        req(0, 12'h304, 0, CTLM[63:32], 0, "R6 ctl read hi");
        req(1, 12'h300, 32'h0000_0001, 0, 0, "R6 ctl lo 2");
        req(1, 12'h304, 32'h0000_0000, 0, 0, "R6 ctl hi 2");
        idle();
        chk("R6 ctl partial", ctl_o, 64'h1);

        // R2: back-to-back commit and read
        req(1, 12'h000, 32'hCAFE_0001, 0, 0, "R2 b2b lo");
        req(1, 12'h004, 32'h0, 0, 0, "R2 b2b hi");
        req(0, 12'h000, 0, 32'hCAFE_0001, 0, "R2 b2b read");
        idle();
        idle();
        idle();
        running = 1'b0;
        finish_up();
    end

endmodule